// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash. After the host has sent a program or erase command sequence, it pulses `start`. The controller then reads status bytes from the flash over a request/acknowledge read port. It judges each byte until it can decide whether the embedded operation succeeded. Two methods are available. Toggle polling compares bit 6 across back-to-back reads. Data polling compares bit 7 with bit 7 of an expected byte; for an erase, the host supplies FFh as the expected byte.

Bit 5 is the flash's timeout flag. Seeing it set does not end polling on its own. The status may stop changing in the same instant that the timeout flag rises, so the controller takes one more look before it declares a failure. When the result is a failure, the controller issues one write of the reset command F0h on a request/acknowledge write port, which returns the flash to array reads. A limit on polling rounds (`MAX_ITER`) means the controller always finishes, even when the flash never settles. The result appears as a one-cycle `done` pulse plus a `pass` level.

The states are as follows.
- IDLE waits for `start`. It goes to TG_FIRST in toggle mode and to DP_READ in data mode.
- TG_FIRST reads and keeps a byte, then goes to TG_SECOND.
- TG_SECOND reads and compares:
  - an equal bit 6 goes to FINISH with a pass;
  - a toggle with bit 5 set goes to TG_CONF_A;
  - a toggle with bit 5 clear goes back to TG_FIRST, or to RST_WR when the round limit is reached.
- TG_CONF_A reads and keeps a byte, then goes to TG_CONF_B.
- TG_CONF_B goes to FINISH with a pass when bit 6 is equal, otherwise to RST_WR.
- DP_READ:
  - a bit 7 match goes to FINISH with a pass;
  - a mismatch with bit 5 set goes to DP_RECHECK;
  - a mismatch with bit 5 clear repeats DP_READ, or goes to RST_WR at the limit.
- DP_RECHECK goes to FINISH with a pass on a match, otherwise to RST_WR.
- RST_WR holds the write until it is acknowledged, then goes to FINISH.
- FINISH pulses `done` and returns to IDLE.

Top module: `poll_ctrl`

## Requirements
- R1: During and right after reset, `rd_req`, `wr_req`, `done` and `pass` are all 0.
- R2: `start` is taken only in IDLE. `use_data_poll` and `expect_byte` are captured at that point. A `start` pulse, or a change on those inputs, while a poll is in progress has no effect on the reads, the write or the result.
- R3: In toggle mode the controller reads two bytes. If bit 6 is the same in both, the result is pass after exactly 2 reads.
- R4: In toggle mode, if bit 6 differs and bit 5 of the second byte of the pair is 0, a fresh pair of reads is taken and judged by the same rules.
- R5: In toggle mode, if bit 6 differs and bit 5 of the second byte is 1, exactly one more pair is read. An equal bit 6 in that pair gives pass; a difference gives fail.
- R6: In data mode each round is one read. If bit 7 equals bit 7 of the captured expected byte, the result is pass. A mismatch with bit 5 = 0 starts another round.
- R7: In data mode, a mismatch with bit 5 = 1 leads to exactly one more read. A match on that read gives pass; a mismatch gives fail.
- R8: A round that ends inconclusive (toggle with bit 5 = 0, or mismatch with bit 5 = 0) counts toward the limit. When the `MAX_ITER`-th such round ends, the result is fail.
- R9: A fail result issues exactly one write of data F0h. `wr_req` is held until `wr_ack`. A pass result issues no write.
- R10: `rd_req` is held until `rd_ack`, and `rd_data` is taken in the acknowledge cycle. `rd_req` and `wr_req` are never high together, and both are low while `done` is high.
- R11: `done` is high for exactly one cycle per accepted start. `pass` is 0 from the cycle after an accepted `start`. It takes its value with `done` and then holds it until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin polling |
| use_data_poll | input | 1 | 1 selects data polling (bit 7), 0 selects toggle polling (bit 6) |
| expect_byte | input | DW | Expected data for data polling (FFh for erase) |
| rd_req | output | 1 | Read request to the flash |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid in this cycle |
| rd_data | input | DW | Byte returned by the flash |
| wr_req | output | 1 | Write request for the reset command |
| wr_ack | input | 1 | Write acknowledge |
| wr_data | output | DW | Write data (F0h while `wr_req` is high) |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last poll, valid from `done` onward |

## Verification
The hardest paths to reach are those where bit 5 rises during a toggle or a mismatch. These need a specific run of bytes: a toggling pair whose second byte carries the timeout flag, followed by a settled or still-toggling confirmation pair. They also include the path where inconclusive rounds run on until the round limit. The bench replaces the flash with a responder. The responder produces the n-th returned byte from a sweep index, two bits per read for the first several reads, followed by a fixed tail that never settles. Sweeping every index on a small round limit therefore covers every ordering of settle, toggle and timeout across the first rounds, and every path that ends at the limit. A directed case pulses `start` and flips the mode input in the middle of a long poll.

// File: rtl/poll_pkg.sv
package poll_pkg;

    // Status bit positions inside a returned byte; the evaluation depends on these.
    localparam int TOGGLE_POS  = 6;
    localparam int DPOLL_POS   = 7;
    localparam int TIMEOUT_POS = 5;

    // Command byte that returns the flash to array reads.
    localparam logic [7:0] RESET_CMD = 8'hF0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TG_FIRST,
        ST_TG_SECOND,
        ST_TG_CONF_A,
        ST_TG_CONF_B,
        ST_DP_READ,
        ST_DP_RECHECK,
        ST_RST_WR,
        ST_FINISH
    } poll_state_t;

endpackage

// File: rtl/poll_iter_cnt.sv
module poll_iter_cnt #(
    parameter int MAX_ITER = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = (MAX_ITER < 2) ? 1 : $clog2(MAX_ITER + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_ITER - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !at_limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // High while the round in progress is the last one allowed.
    assign at_limit = (cnt_q == LAST);

endmodule

// File: rtl/poll_eval.sv
module poll_eval
    import poll_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] prev_byte,
    input  logic [DW-1:0] cur_byte,
    input  logic [DW-1:0] ref_byte,
    output logic          toggled,
    output logic          dp_match,
    output logic          timeout_set
);
    always_comb begin
        toggled     = prev_byte[TOGGLE_POS] ^ cur_byte[TOGGLE_POS];
        dp_match    = (cur_byte[DPOLL_POS] == ref_byte[DPOLL_POS]);
        timeout_set = cur_byte[TIMEOUT_POS];
    end

endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
    import poll_pkg::*;
#(
    parameter int DW       = 8,
    parameter int MAX_ITER = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          use_data_poll,
    input  logic [DW-1:0] expect_byte,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          wr_req,
    input  logic          wr_ack,
    output logic [DW-1:0] wr_data,
    output logic          done,
    output logic          pass
);
    localparam logic [DW-1:0] RST_WORD = DW'(RESET_CMD);

    poll_state_t state_q, state_d;

    logic [DW-1:0] prev_q;
    logic [DW-1:0] exp_q;
    logic          pass_q;
    logic          accept;
    logic          keep_byte;
    logic          set_pass;
    logic          round_inc;
    logic          at_limit;
    logic          toggled;
    logic          dp_match;
    logic          timeout_set;

    poll_eval #(.DW(DW)) u_eval (
        .prev_byte   (prev_q),
        .cur_byte    (rd_data),
        .ref_byte    (exp_q),
        .toggled     (toggled),
        .dp_match    (dp_match),
        .timeout_set (timeout_set)
    );

    poll_iter_cnt #(.MAX_ITER(MAX_ITER)) u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .inc      (round_inc),
        .at_limit (at_limit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers: captured config, kept byte, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            exp_q  <= '0;
            pass_q <= 1'b0;
        end else begin
            if (accept) begin
                exp_q  <= expect_byte;
                pass_q <= 1'b0;
            end else if (set_pass) begin
                pass_q <= 1'b1;
            end
            if (keep_byte) begin
                prev_q <= rd_data;
            end
        end
    end

    // Next state and transition strobes
    always_comb begin
        state_d   = state_q;
        accept    = 1'b0;
        keep_byte = 1'b0;
        set_pass  = 1'b0;
        round_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    state_d = use_data_poll ? ST_DP_READ : ST_TG_FIRST;
                end
            end
            ST_TG_FIRST: begin
                if (rd_ack) begin
                    keep_byte = 1'b1;
                    state_d   = ST_TG_SECOND;
                end
            end
            ST_TG_SECOND: begin
                if (rd_ack) begin
                    if (!toggled) begin
                        set_pass = 1'b1;
                        state_d  = ST_FINISH;
                    end else if (timeout_set) begin
                        state_d = ST_TG_CONF_A;
                    end else if (at_limit) begin
                        state_d = ST_RST_WR;
                    end else begin
                        round_inc = 1'b1;
                        state_d   = ST_TG_FIRST;
                    end
                end
            end
            ST_TG_CONF_A: begin
                if (rd_ack) begin
                    keep_byte = 1'b1;
                    state_d   = ST_TG_CONF_B;
                end
            end
            ST_TG_CONF_B: begin
                if (rd_ack) begin
                    if (!toggled) begin
                        set_pass = 1'b1;
                        state_d  = ST_FINISH;
                    end else begin
                        state_d = ST_RST_WR;
                    end
                end
            end
            ST_DP_READ: begin
                if (rd_ack) begin
                    if (dp_match) begin
                        set_pass = 1'b1;
                        state_d  = ST_FINISH;
                    end else if (timeout_set) begin
                        state_d = ST_DP_RECHECK;
                    end else if (at_limit) begin
                        state_d = ST_RST_WR;
                    end else begin
                        round_inc = 1'b1;
                        state_d   = ST_DP_READ;
                    end
                end
            end
            ST_DP_RECHECK: begin
                if (rd_ack) begin
                    if (dp_match) begin
                        set_pass = 1'b1;
                        state_d  = ST_FINISH;
                    end else begin
                        state_d = ST_RST_WR;
                    end
                end
            end
            ST_RST_WR: begin
                if (wr_ack) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        done    = 1'b0;
        wr_data = '0;
        unique case (state_q)
            ST_TG_FIRST, ST_TG_SECOND, ST_TG_CONF_A,
            ST_TG_CONF_B, ST_DP_READ, ST_DP_RECHECK: rd_req = 1'b1;
            ST_RST_WR: begin
                wr_req  = 1'b1;
                wr_data = RST_WORD;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
        pass = pass_q;
    end

endmodule

// File: rtl/poll_ctrl_chk.sv
module poll_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic rd_req,
    input logic rd_ack,
    input logic wr_req,
    input logic wr_ack,
    input logic done,
    input logic pass
);
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R10

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> rd_req); // R10

    AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_req && !wr_req)); // R10

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req); // R9

    AST_FAIL_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> (done && !pass)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass) |-> (done || $past(start))); // R11

endmodule

bind poll_ctrl poll_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .rd_req (rd_req),
    .rd_ack (rd_ack),
    .wr_req (wr_req),
    .wr_ack (wr_ack),
    .done   (done),
    .pass   (pass)
);

// File: tb/poll_ctrl_tb.sv
module poll_ctrl_tb;
    localparam int DW       = 8;
    localparam int MAXI     = 4;
    localparam int WD_LIMIT = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          use_dp = 1'b0;
    logic [DW-1:0] exp_b = '0;
    logic          rd_req;
    logic          rd_ack = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic          wr_req;
    logic          wr_ack = 1'b0;
    logic [DW-1:0] wr_data;
    logic          done;
    logic          pass;

    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    bit   ended = 1'b0;
    bit   seq_rst = 1'b0;
    int   rd_cnt = 0;
    int   wr_cnt = 0;
    logic [7:0] last_wr = '0;
    logic       cur_m = 1'b0;
    int         cur_code = 0;
    logic [7:0] cur_exp = '0;

    poll_ctrl #(.DW(DW), .MAX_ITER(MAXI)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .use_data_poll (use_dp),
        .expect_byte   (exp_b),
        .rd_req        (rd_req),
        .rd_ack        (rd_ack),
        .rd_data       (rd_data),
        .wr_req        (wr_req),
        .wr_ack        (wr_ack),
        .wr_data       (wr_data),
        .done          (done),
        .pass          (pass)
    );

    // 20 time-unit period: 50 MHz with a 1 ns unit
    always #10 clk = ~clk;

    // Byte number i that the stand-in flash returns for sweep index code.
    function automatic logic [7:0] byte_at(logic m, int code, logic [7:0] e, int i);
        int c;
        logic b7, b6, b5;
        logic [4:0] lo;
        lo = 5'(i * 5 + code);
        if (!m) begin
            if (i < 6) begin
                c = (code >> (2 * i)) & 3;
                b6 = c[1];
                b5 = c[0];
            end else begin
                b6 = i[0];
                b5 = 1'b0;
            end
            b7 = i[1];
        end else begin
            if (i < 5) begin
                c = (code >> (2 * i)) & 3;
                b7 = c[1];
                b5 = c[0];
            end else begin
                b7 = ~e[7];
                b5 = 1'b0;
            end
            b6 = i[0];
        end
        return {b7, b6, b5, lo};
    endfunction

    // Expected outcome from the requirements; why holds the deciding rule number.
    task automatic model(input logic m, input int code, input logic [7:0] e,
                         output bit p, output int rds, output int why);
        int idx;
        int rounds;
        logic [7:0] a, b, c, d;
        idx = 0; rounds = 0; p = 1'b0; why = 8;
        for (int k = 0; k < 64; k++) begin
            if (!m) begin
                a = byte_at(m, code, e, idx);
                b = byte_at(m, code, e, idx + 1);
                idx += 2;
                if (a[6] == b[6]) begin
                    p = 1'b1; why = (rounds == 0) ? 3 : 4; break;
                end
                if (b[5]) begin
                    c = byte_at(m, code, e, idx);
                    d = byte_at(m, code, e, idx + 1);
                    idx += 2;
                    p = (c[6] == d[6]); why = 5; break;
                end
            end else begin
                a = byte_at(m, code, e, idx);
                idx += 1;
                if (a[7] == e[7]) begin
                    p = 1'b1; why = 6; break;
                end
                if (a[5]) begin
                    b = byte_at(m, code, e, idx);
                    idx += 1;
                    p = (b[7] == e[7]); why = 7; break;
                end
            end
            rounds++;
            if (rounds == MAXI) begin
                p = 1'b0; why = 8; break;
            end
        end
        rds = idx;
    endtask

    function automatic string tag_of(int why);
        case (why)
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Stand-in flash: acknowledges each request one cycle after it appears.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (seq_rst) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
            rd_ack <= 1'b0;
            wr_ack <= 1'b0;
        end else begin
            if (rd_req && !rd_ack) begin
                rd_ack  <= 1'b1;
                rd_data <= byte_at(cur_m, cur_code, cur_exp, rd_cnt);
                rd_cnt  <= rd_cnt + 1;
            end else begin
                rd_ack <= 1'b0;
            end
            if (wr_req && !wr_ack) begin
                wr_ack  <= 1'b1;
                wr_cnt  <= wr_cnt + 1;
                last_wr <= wr_data;
            end else begin
                wr_ack <= 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > WD_LIMIT && !ended) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles at most", cyc, WD_LIMIT);
            finish_run();
        end
    end

    // One poll; stray_at > 0 pulses start and flips the mode that many cycles into it.
    task automatic run_case(logic m, int code, logic [7:0] e, int stray_at);
        bit   p_exp;
        int   r_exp;
        int   why;
        int   w;
        string t;
        model(m, code, e, p_exp, r_exp, why);
        t = tag_of(why);
        @(negedge clk);
        cur_m = m; cur_code = code; cur_exp = e;
        use_dp = m; exp_b = e; start = 1'b1; seq_rst = 1'b1;
        @(negedge clk);
        start = 1'b0; seq_rst = 1'b0;
        chk(pass == 1'b0, "R11", "pass cleared after start", int'(pass), 0);
        w = 0;
        while (!done && w < 400) begin
            @(negedge clk);
            w++;
            if (stray_at > 0 && w == stray_at) begin
                start = 1'b1; use_dp = ~m; exp_b = ~e;
            end else if (stray_at > 0 && w == stray_at + 1) begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (!done) begin
            chk(1'b0, "R11", "done never seen", 0, 1);
        end else begin
            chk(pass == p_exp, t, "pass result", int'(pass), int'(p_exp));
            chk(rd_cnt == r_exp, t, "read count", rd_cnt, r_exp);
            chk(wr_cnt == (p_exp ? 0 : 1), "R9", "reset writes", wr_cnt, p_exp ? 0 : 1);
            if (!p_exp) chk(last_wr == 8'hF0, "R9", "reset write data", int'(last_wr), 8'hF0);
            chk(!rd_req && !wr_req, "R10", "requests low at done", int'({rd_req, wr_req}), 0);
            @(negedge clk);
            chk(done == 1'b0, "R11", "done width", int'(done), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({rd_req, wr_req, done, pass} == 4'b0, "R1", "outputs in reset",
            int'({rd_req, wr_req, done, pass}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rd_req, wr_req, done, pass} == 4'b0, "R1", "outputs after reset",
            int'({rd_req, wr_req, done, pass}), 0);

        // R2: stray start and mode flip mid-poll on a run that reaches the round limit
        run_case(1'b0, 32'h888, 8'h00, 5);
        chk(wr_cnt == 1, "R2", "stray start ignored, single write", wr_cnt, 1);

        // R11: pass holds after a passing poll
        run_case(1'b0, 0, 8'h00, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(pass == 1'b1, "R11", "pass held", int'(pass), 1);
        end

        // Toggle-mode sweep: R3 R4 R5 R8
        for (int code = 0; code < 4096; code++) begin
            run_case(1'b0, code, 8'h00, 0);
        end
        // Data-mode sweep with an erase and a program expectation: R6 R7 R8
        for (int code = 0; code < 1024; code++) begin
            run_case(1'b1, code, 8'hFF, 0);
        end
        for (int code = 0; code < 1024; code++) begin
            run_case(1'b1, code, 8'h3C, 0);
        end
        finish_run();
    end

endmodule